// File: doc/BRIEF.md
# Shift-and-Rotate Operand Former

This combinational block builds the second source operand of a 32-bit data-processing instruction. It also produces the carry that the shifting stage hands to the flag logic. The instruction word is decoded into one of three operand forms:

- a rotated 8-bit constant;
- a register value shifted by a 5-bit constant;
- a register value shifted by an amount read from a second register.

The shift is one of four types: logical left, logical right, arithmetic right or rotate right.

The block does not contain a register file. The caller reads the shifted register and the low byte of the amount register, and supplies both. It also supplies a flag that marks the shifted register as the program counter, the program counter's value as it is normally read, and the current carry flag.

The block returns the operand, the shifter carry, and a strobe. The strobe says whether that carry should be written back to the flags. The carry is produced in every cycle; the strobe only says whether the instruction wants it.

Top module: `shifter_operand_unit`

## Requirements
- R1: When instruction bit 25 is 1, the operand is instruction bits 7:0, zero-extended to 32 bits and rotated right by twice the value of bits 11:8. The carry is operand bit 31 when that rotation is nonzero, and the incoming carry when it is zero.
- R2: When bit 25 is 0, bits 3:0 name the shifted register and bits 6:5 pick the type (00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right). If bit 4 is 1, the amount is the 8-bit `rs_low` input. If bit 4 is 0, the amount is bits 11:7.
- R3: A logical left shift by n in 1..31 gives the carry Rm bit (32-n). A shift by exactly 32 gives operand 0 and carry Rm bit 0. A shift by more than 32 gives operand 0 and carry 0.
- R4: A logical right shift by n in 1..31 gives the carry Rm bit (n-1). A shift by exactly 32 gives operand 0 and carry Rm bit 31. A shift by more than 32 gives operand 0 and carry 0.
- R5: An arithmetic right shift by n in 1..31 gives the carry Rm bit (n-1). Any amount of 32 or more gives an operand with every bit equal to Rm bit 31, and a carry equal to that same bit.
- R6: A rotate right by a register amount rotates by the amount modulo 32, and the carry is the last bit rotated out. When the amount is a nonzero multiple of 32, the operand is Rm and the carry is Rm bit 31.
- R7: A constant amount of 0 is reinterpreted. For logical left, Rm passes through unchanged and the carry is unchanged. For logical right and arithmetic right, the shift is treated as a shift by 32.
- R8: Rotate right by a constant 0 is a one-bit rotate through the carry. The operand is the old carry above Rm bits 31:1, and the carry is Rm bit 0.
- R9: A register amount of 0 leaves the operand equal to Rm and the carry equal to the incoming carry, for all four types.
- R10: When `rm_is_pc` is 1, the value shifted is `pc_val + 4`, for both the constant-amount and the register-amount forms.
- R11: `carry_valid` is 1 when bit 20 is 1, or when bits 24:21 are 1000 or 1001 (the two flag-only test operations). Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Value of the shifted register |
| rs_low | input | 8 | Low byte of the amount register |
| rm_is_pc | input | 1 | Shifted register is the program counter |
| pc_val | input | 32 | Program counter value as normally read |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry |
| carry_valid | output | 1 | Carry should update the flags |

## Verification
The rotated constant is tried with zero and nonzero rotations. This separates the case where the carry is kept from the case where it is taken from bit 31.

Register amounts of 0, 1, 31, 32, 33 and large values are applied to each shift type. This shows up any confusion between the exact-32 carry rules, the above-32 carry rules and the modulo-32 rotate rule.

Constant amounts of zero are tried for all four types, which separates the pass-through, the shift-by-32 reinterpretation and the rotate through carry.

Random instruction words with a biased amount byte cover the rest. Those words set the program-counter flag and the opcode bits that drive the strobe.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int unsigned XLEN      = 32;
    localparam int unsigned AMT_W     = 8;
    localparam int unsigned SH_W      = $clog2(XLEN);
    localparam int unsigned IMM_W     = 8;
    localparam int unsigned PC_AHEAD  = 4;

    // instruction field positions
    localparam int unsigned B_IMMFORM = 25;
    localparam int unsigned B_SETFLG  = 20;
    localparam int unsigned B_REGAMT  = 4;
    localparam logic [3:0]  OPC_TEST0 = 4'b1000;
    localparam logic [3:0]  OPC_TEST1 = 4'b1001;

    typedef enum logic [2:0] {
        K_LSL = 3'd0,
        K_LSR = 3'd1,
        K_ASR = 3'd2,
        K_ROR = 3'd3,
        K_RRX = 3'd4
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e            kind;
        logic [AMT_W-1:0]       amt;
        logic [XLEN-1:0]        src;
    } shift_req_t;

    typedef struct packed {
        logic [XLEN-1:0]        value;
        logic                   carry;
    } shift_res_t;

    function automatic logic [XLEN-1:0] eff_rm(input logic [XLEN-1:0] rm,
                                               input logic is_pc,
                                               input logic [XLEN-1:0] pc);
        return is_pc ? pc + XLEN'(PC_AHEAD) : rm;
    endfunction

    function automatic logic [AMT_W-1:0] full_width_amt();
        return AMT_W'(XLEN);
    endfunction

endpackage

// File: rtl/sop_decode.sv
module sop_decode
    import sop_pkg::*;
(
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  rm_val,
    input  logic [AMT_W-1:0] rs_low,
    input  logic             rm_is_pc,
    input  logic [XLEN-1:0]  pc_val,
    output shift_req_t       req
);
    logic [4:0] imm_amt;

    always_comb begin
        imm_amt  = instr[11:7];
        req.kind = shift_kind_e'({1'b0, instr[6:5]});
        req.amt  = '0;
        req.src  = eff_rm(rm_val, rm_is_pc, pc_val);
        if (instr[B_IMMFORM]) begin
            // rotated constant: rotate amount is twice the 4-bit field
            req.kind = K_ROR;
            req.amt  = AMT_W'({instr[11:8], 1'b0});
            req.src  = XLEN'(instr[IMM_W-1:0]);
        end else if (instr[B_REGAMT]) begin
            req.amt  = rs_low;
        end else if (imm_amt == '0) begin
            unique case (instr[6:5])
                2'b00:   req.amt = '0;
                2'b01,
                2'b10:   req.amt = full_width_amt();
                default: req.kind = K_RRX;
            endcase
        end else begin
            req.amt  = AMT_W'(imm_amt);
        end
    end
endmodule

// File: rtl/sop_shift_core.sv
module sop_shift_core
    import sop_pkg::*;
(
    input  shift_req_t req,
    input  logic       carry_in,
    output shift_res_t res
);
    logic [SH_W-1:0]      s;
    logic                 beyond;   // amount >= XLEN
    logic                 exact;    // amount == XLEN
    logic [XLEN:0]        w_lsl;
    logic [XLEN:0]        w_lsr;
    logic signed [XLEN:0] w_asr_in;
    logic signed [XLEN:0] w_asr;
    logic [XLEN-1:0]      w_ror;
    logic [XLEN-1:0]      rm;

    always_comb begin
        rm       = req.src;
        s        = req.amt[SH_W-1:0];
        beyond   = |req.amt[AMT_W-1:SH_W];
        exact    = (req.amt == AMT_W'(XLEN));
        w_lsl    = {1'b0, rm} << s;
        w_lsr    = {rm, 1'b0} >> s;
        w_asr_in = {rm, 1'b0};
        w_asr    = w_asr_in >>> s;
        w_ror    = (rm >> s) | (rm << (XLEN - int'(s)));

        res.value = rm;
        res.carry = carry_in;
        if (req.kind == K_RRX) begin
            res.value = {carry_in, rm[XLEN-1:1]};
            res.carry = rm[0];
        end else if (req.amt != '0) begin
            unique case (req.kind)
                K_LSL: begin
                    res.value = beyond ? '0 : w_lsl[XLEN-1:0];
                    res.carry = !beyond ? w_lsl[XLEN] : (exact ? rm[0] : 1'b0);
                end
                K_LSR: begin
                    res.value = beyond ? '0 : w_lsr[XLEN:1];
                    res.carry = !beyond ? w_lsr[0] : (exact ? rm[XLEN-1] : 1'b0);
                end
                K_ASR: begin
                    res.value = beyond ? {XLEN{rm[XLEN-1]}} : w_asr[XLEN:1];
                    res.carry = beyond ? rm[XLEN-1] : w_asr[0];
                end
                default: begin
                    res.value = w_ror;
                    res.carry = w_ror[XLEN-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/sop_carry_gate.sv
module sop_carry_gate
    import sop_pkg::*;
#(
    parameter int unsigned N_TEST = 2,
    parameter logic [4*N_TEST-1:0] TEST_OPS = {OPC_TEST1, OPC_TEST0}
) (
    input  logic [31:0] instr,
    output logic        carry_valid
);
    logic [N_TEST-1:0] hit;

    for (genvar g = 0; g < N_TEST; g++) begin : g_test
        assign hit[g] = (instr[24:21] == TEST_OPS[4*g +: 4]);
    end

    assign carry_valid = instr[B_SETFLG] | (|hit);
endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
    import sop_pkg::*;
(
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  rm_val,
    input  logic [AMT_W-1:0] rs_low,
    input  logic             rm_is_pc,
    input  logic [XLEN-1:0]  pc_val,
    input  logic             carry_in,
    output logic [XLEN-1:0]  operand,
    output logic             carry_out,
    output logic             carry_valid
);
    shift_req_t req;
    shift_res_t res;

    sop_decode u_decode (
        .instr    (instr),
        .rm_val   (rm_val),
        .rs_low   (rs_low),
        .rm_is_pc (rm_is_pc),
        .pc_val   (pc_val),
        .req      (req)
    );

    sop_shift_core u_core (
        .req      (req),
        .carry_in (carry_in),
        .res      (res)
    );

    sop_carry_gate u_gate (
        .instr       (instr),
        .carry_valid (carry_valid)
    );

    assign operand   = res.value;
    assign carry_out = res.carry;

    // port-level checks of the corner encodings
    logic [XLEN-1:0] chk_rm;
    always_comb begin
        chk_rm = rm_is_pc ? pc_val + XLEN'(PC_AHEAD) : rm_val;
        if (!$isunknown({instr, rm_val, rs_low, rm_is_pc, pc_val, carry_in})) begin
            if (instr[25] && instr[11:8] == 4'd0)
                p_const_norot_r1: assert (operand == XLEN'(instr[7:0]) && carry_out == carry_in);
            if (!instr[25] && instr[4] && rs_low == '0)
                p_regzero_pass_r9: assert (operand == chk_rm && carry_out == carry_in);
            if (!instr[25] && !instr[4] && instr[11:7] == 5'd0 && instr[6:5] == 2'b01)
                p_lsr_zero_is32_r7: assert (operand == '0 && carry_out == chk_rm[XLEN-1]);
            if (!instr[25] && instr[4] && instr[6:5] == 2'b10 && rs_low >= 8'd32)
                p_asr_sat_r5: assert (operand == {XLEN{chk_rm[XLEN-1]}} && carry_out == chk_rm[XLEN-1]);
            if (!instr[25] && !instr[4] && instr[11:7] == 5'd0 && instr[6:5] == 2'b11)
                p_rrx_r8: assert (operand == {carry_in, chk_rm[XLEN-1:1]} && carry_out == chk_rm[0]);
            if (instr[20])
                p_setflag_valid_r11: assert (carry_valid);
        end
    end
endmodule

// File: tb/test_shifter_operand_unit.sv
`timescale 1ns/1ps
module test_shifter_operand_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic [31:0] rm_val = '0;
    logic [7:0]  rs_low = '0;
    logic        rm_is_pc = 1'b0;
    logic [31:0] pc_val = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;
    logic        carry_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    shifter_operand_unit i_shifter_operand_unit (
        .instr       (instr),
        .rm_val      (rm_val),
        .rs_low      (rs_low),
        .rm_is_pc    (rm_is_pc),
        .pc_val      (pc_val),
        .carry_in    (carry_in),
        .operand     (operand),
        .carry_out   (carry_out),
        .carry_valid (carry_valid)
    );

    // behavioural reference: shifts performed one bit at a time
    task automatic model(input logic [31:0] ins, input logic [31:0] rm, input logic [7:0] rs,
                         input logic ispc, input logic [31:0] pc, input logic cin,
                         output logic [31:0] v, output logic c, output logic vld,
                         output string tag);
        int n;
        int kind;
        vld = ins[20] || ins[24:21] == 4'b1000 || ins[24:21] == 4'b1001;
        c = cin;
        if (ins[25]) begin
            v = {24'd0, ins[7:0]};
            n = 2 * int'(ins[11:8]);
            tag = "R1";
            for (int k = 0; k < n; k++) begin
                c = v[0];
                v = {v[0], v[31:1]};
            end
            return;
        end
        v = ispc ? pc + 32'd4 : rm;
        kind = int'(ins[6:5]);
        if (ins[4]) begin
            n = int'(rs);
            case (kind)
                0: tag = "R2,R3";
                1: tag = "R2,R4";
                2: tag = "R2,R5";
                default: tag = "R2,R6";
            endcase
            if (n == 0) tag = "R9";
        end else begin
            n = int'(ins[11:7]);
            tag = "R2";
            if (n == 0) begin
                tag = "R7";
                if (kind == 1 || kind == 2) n = 32;
                if (kind == 3) begin
                    c = v[0];
                    v = {cin, v[31:1]};
                    tag = ispc ? "R10,R8" : "R8";
                    return;
                end
            end
        end
        for (int k = 0; k < n; k++) begin
            case (kind)
                0: begin c = v[31]; v = v << 1; end
                1: begin c = v[0];  v = v >> 1; end
                2: begin c = v[0];  v = {v[31], v[31:1]}; end
                default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        if (ispc) tag = {"R10,", tag};
    endtask

    task automatic apply(input logic [31:0] ins, input logic [31:0] rm, input logic [7:0] rs,
                         input logic ispc, input logic [31:0] pc, input logic cin);
        logic [31:0] ev;
        logic ec;
        logic evld;
        string tag;
        @(posedge clk);
        instr = ins; rm_val = rm; rs_low = rs; rm_is_pc = ispc; pc_val = pc; carry_in = cin;
        model(ins, rm, rs, ispc, pc, cin, ev, ec, evld, tag);
        @(negedge clk);
        checks++;
        if (operand !== ev) begin
            errors++;
            $display("FAIL %s operand instr=%h: actual=%h expected=%h", tag, ins, operand, ev);
        end
        checks++;
        if (carry_out !== ec) begin
            errors++;
            $display("FAIL %s carry instr=%h: actual=%b expected=%b", tag, ins, carry_out, ec);
        end
        checks++;
        if (carry_valid !== evld) begin
            errors++;
            $display("FAIL R11 carry_valid instr=%h: actual=%b expected=%b", ins, carry_valid, evld);
        end
    endtask

    // instruction builders
    function automatic logic [31:0] f_const(input logic [3:0] rot, input logic [7:0] imm);
        return {6'd0, 1'b1, 4'b0100, 1'b0, 8'd0, rot, imm};
    endfunction
    function automatic logic [31:0] f_imm(input logic [1:0] ty, input logic [4:0] amt);
        return {6'd0, 1'b0, 4'b1101, 1'b1, 8'd0, amt, ty, 1'b0, 4'd2};
    endfunction
    function automatic logic [31:0] f_reg(input logic [1:0] ty);
        return {6'd0, 1'b0, 4'b1101, 1'b0, 8'd0, 4'd3, 1'b0, ty, 1'b1, 4'd2};
    endfunction

    localparam logic [31:0] PAT = 32'h8000_0001;

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: all-zero inputs give a zero operand, no carry, no strobe
        apply(32'd0, 32'd0, 8'd0, 1'b0, 32'd0, 1'b0);

        // R1 rotated constant, zero and nonzero rotations
        apply(f_const(4'd0, 8'hA5), 32'd0, 8'd0, 1'b0, 32'd0, 1'b1);
        apply(f_const(4'd1, 8'h03), 32'd0, 8'd0, 1'b0, 32'd0, 1'b0);
        apply(f_const(4'd4, 8'h7F), 32'd0, 8'd0, 1'b0, 32'd0, 1'b1);
        apply(f_const(4'd15, 8'hFF), 32'd0, 8'd0, 1'b0, 32'd0, 1'b0);

        // R3 R4 R5 R6 R9 register amounts around the word width
        for (int ty = 0; ty < 4; ty++) begin
            apply(f_reg(2'(ty)), PAT, 8'd0,   1'b0, 32'd0, 1'b1);
            apply(f_reg(2'(ty)), PAT, 8'd1,   1'b0, 32'd0, 1'b0);
            apply(f_reg(2'(ty)), PAT, 8'd31,  1'b0, 32'd0, 1'b0);
            apply(f_reg(2'(ty)), PAT, 8'd32,  1'b0, 32'd0, 1'b0);
            apply(f_reg(2'(ty)), PAT, 8'd33,  1'b0, 32'd0, 1'b1);
            apply(f_reg(2'(ty)), PAT, 8'd64,  1'b0, 32'd0, 1'b0);
            apply(f_reg(2'(ty)), 32'h4000_0002, 8'd255, 1'b0, 32'd0, 1'b1);
        end

        // R7 R8 constant zero encodings
        for (int ty = 0; ty < 4; ty++) begin
            apply(f_imm(2'(ty), 5'd0), PAT, 8'd0, 1'b0, 32'd0, 1'b0);
            apply(f_imm(2'(ty), 5'd0), 32'h7FFF_FFFE, 8'd0, 1'b0, 32'd0, 1'b1);
            apply(f_imm(2'(ty), 5'd5), 32'hF0F0_1234, 8'd0, 1'b0, 32'd0, 1'b0);
        end

        // R10 program counter as the shifted register
        apply(f_imm(2'b00, 5'd1), 32'hDEAD_BEEF, 8'd0, 1'b1, 32'h0000_1000, 1'b0);
        apply(f_reg(2'b01), 32'hDEAD_BEEF, 8'd4, 1'b1, 32'hFFFF_FFFC, 1'b0);

        // R11 strobe from the test opcodes with the set-flags bit clear
        apply({7'd0, 4'b1000, 1'b0, 20'h0_0A60}, PAT, 8'd0, 1'b0, 32'd0, 1'b1);
        apply({7'd0, 4'b1001, 1'b0, 20'h0_0060}, PAT, 8'd0, 1'b0, 32'd0, 1'b0);
        apply({7'd0, 4'b1010, 1'b0, 20'h0_0060}, PAT, 8'd0, 1'b0, 32'd0, 1'b0);

        // random mix with biased amount bytes
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] rs;
            case ($urandom_range(0, 3))
                0: rs = 8'($urandom_range(30, 34));
                1: rs = 8'($urandom_range(0, 2));
                default: rs = 8'($urandom);
            endcase
            apply($urandom, $urandom, rs, 1'($urandom), $urandom, 1'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule